// File: doc/BRIEF.md
# Output Protection Timing Supervisor

This block sequences the time-based protections of a high-side output driver. It receives flags that have already been synchronised to its clock: high-side overcurrent, severe overcurrent (three times the set limit), supply above the overvoltage trip point, supply below the trip point minus hysteresis, high-side switch on, input-mode enable and logic-supply-good. From these flags it derives four outputs. The first is a deglitched active-low overcurrent indicator. The second is a protect-mode request that asks for reduced edge slew rate. The third is a lockout that forces both output switches off. The fourth is an overvoltage status indicator.

Every delay is a saturating tick counter that restarts whenever its qualifying flag drops before the counter expires. The parameter `TICKS_PER_US` ties these counters to real time. The open-drain pins are modelled as drive-low enables: 1 pulls the pin low, and 0 releases it to read high. The analog sensing and the slew-rate circuitry are outside this block.

Top module: `outprot_supervisor`

## Requirements
- R1: `ocDrvLow` goes to 1 after the clock edge at which the overcurrent qualifier (`hsOverCur` and `hsSwitchOn` both 1, `inputModeEn` 0) has been sampled true on OC_TICKS+1 consecutive edges, where OC_TICKS = 8·TICKS_PER_US. A shorter run leaves it at 0.
- R2: `ocDrvLow` returns to 0 at the first edge where `hsOverCur` is sampled 0 or where `hsSwitchOn` is sampled 0. The second case covers a thermal shutdown of the switch.
- R3: While `inputModeEn` is 1, `ocDrvLow` stays 0 whatever the current flags do.
- R4: From idle, a sampled `severeOverCur` raises `protectSlow` after that edge. It then holds for exactly PROT_TICKS = 4000·TICKS_PER_US cycles. No other output reacts to it.
- R5: If `severeOverCur` is sampled 1 at the final edge of a protect window, a fresh window of PROT_TICKS cycles follows with no gap. If the flag was present only earlier in the window, the window ends on time.
- R6: `switchLockout` goes to 1 after `supplyOverThr` has been sampled 1 on OV_TICKS+1 consecutive edges, where OV_TICKS = 200·TICKS_PER_US. A shorter excursion has no effect on it.
- R7: Once set, `switchLockout` holds through any supply level until `supplyUnderHyst` is sampled 1. It clears at that edge, and this clear takes priority over a new set.
- R8: With `logicSupplyOk` at 1, `ovStatDrvLow` equals `supplyOverThr` sampled one edge earlier. This output does not wait for the filter.
- R9: With `logicSupplyOk` at 0, `ovStatDrvLow` equals the build parameter `OVSTAT_FORCE_LOW`. A value of 1 drives the pin low, and a value of 0 leaves it high-impedance.
- R10: While `rst` is sampled 1, all four outputs are 0 on the following cycle and every timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsOverCur | input | 1 | High-side current above set limit |
| severeOverCur | input | 1 | Current above three times set limit |
| supplyOverThr | input | 1 | Supply above overvoltage trip point |
| supplyUnderHyst | input | 1 | Supply below trip point minus hysteresis |
| hsSwitchOn | input | 1 | High-side switch is conducting |
| inputModeEn | input | 1 | Pin operates as digital input |
| logicSupplyOk | input | 1 | Logic supply above its power-on level |
| ocDrvLow | output | 1 | Overcurrent indicator pull-down enable |
| protectSlow | output | 1 | Reduced-slew protect-mode request |
| switchLockout | output | 1 | Force both output switches off |
| ovStatDrvLow | output | 1 | Overvoltage status pull-down enable |

## Verification
Several functions can act in the same cycle. A severe short raises the plain overcurrent flag as well, so the protect window and the overcurrent deglitch run at the same time. Likewise, an overvoltage excursion drives the unfiltered status in the same cycle in which the lockout filter starts counting. The stimulus overlaps these conditions: it holds a severe short across a protect-window boundary while the overcurrent run crosses its threshold, and it toggles the logic supply during an overvoltage event. A behavioural model compares every output on every cycle, so a wrong interaction shows up in the exact cycle where it happens.

// File: rtl/outprot_pkg.sv
package outprot_pkg;
  // Strobes from control to the timer datapath
  typedef struct packed {
    logic ocRun;
    logic protRun;
    logic protClr;
    logic ovRun;
  } tmrCtrl_t;

  // Terminal-count flags from datapath back to control
  typedef struct packed {
    logic ocDone;
    logic protDone;
    logic ovDone;
  } tmrStat_t;
endpackage

// File: rtl/outprot_timer.sv
module outprot_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic atLimit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign atLimit = (cnt == LIM);

  // R1
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (atLimit && run && !clr) |=> atLimit);
endmodule

// File: rtl/outprot_datapath.sv
module outprot_datapath
  import outprot_pkg::*;
#(
  parameter int OC_TICKS   = 32,
  parameter int PROT_TICKS = 16000,
  parameter int OV_TICKS   = 800
) (
  input  logic     clk,
  input  logic     rst,
  input  tmrCtrl_t ctrl,
  output tmrStat_t stat
);
  // Overcurrent deglitch: restarts whenever the qualifier drops
  outprot_timer #(.LIMIT(OC_TICKS)) ocTmr_i (
    .clk(clk), .rst(rst), .run(ctrl.ocRun), .clr(!ctrl.ocRun),
    .atLimit(stat.ocDone));

  // Protect window: last cycle flagged at PROT_TICKS-1
  outprot_timer #(.LIMIT(PROT_TICKS - 1)) protTmr_i (
    .clk(clk), .rst(rst), .run(ctrl.protRun), .clr(ctrl.protClr),
    .atLimit(stat.protDone));

  // Overvoltage filter
  outprot_timer #(.LIMIT(OV_TICKS)) ovTmr_i (
    .clk(clk), .rst(rst), .run(ctrl.ovRun), .clr(!ctrl.ovRun),
    .atLimit(stat.ovDone));
endmodule

// File: rtl/outprot_control.sv
module outprot_control
  import outprot_pkg::*;
#(
  parameter bit OVSTAT_FORCE_LOW = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hsOverCur,
  input  logic     severeOverCur,
  input  logic     supplyOverThr,
  input  logic     supplyUnderHyst,
  input  logic     hsSwitchOn,
  input  logic     inputModeEn,
  input  logic     logicSupplyOk,
  input  tmrStat_t stat,
  output tmrCtrl_t ctrl,
  output logic     ocDrvLow,
  output logic     protectSlow,
  output logic     switchLockout,
  output logic     ovStatDrvLow
);
  logic ocQual;

  assign ocQual = hsOverCur && hsSwitchOn && !inputModeEn;

  always_comb begin
    ctrl.ocRun   = ocQual;
    ctrl.ovRun   = supplyOverThr;
    ctrl.protRun = protectSlow;
    ctrl.protClr = !protectSlow || stat.protDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocDrvLow      <= 1'b0;
      protectSlow   <= 1'b0;
      switchLockout <= 1'b0;
      ovStatDrvLow  <= 1'b0;
    end else begin
      ocDrvLow <= ocQual && stat.ocDone;
      if (!protectSlow || stat.protDone) protectSlow <= severeOverCur;
      if (supplyUnderHyst) switchLockout <= 1'b0;
      else if (supplyOverThr && stat.ovDone) switchLockout <= 1'b1;
      ovStatDrvLow <= logicSupplyOk ? supplyOverThr : OVSTAT_FORCE_LOW;
    end
  end

  // R1
  oc_rise_qual_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ocDrvLow) |-> $past(hsOverCur && hsSwitchOn));
  // R2
  oc_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!hsOverCur || !hsSwitchOn) |=> !ocDrvLow);
  // R3
  oc_dimode_chk: assert property (@(posedge clk) disable iff (rst)
    inputModeEn |=> !ocDrvLow);
  // R4
  prot_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(protectSlow) |-> $past(severeOverCur));
  // R5
  prot_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(protectSlow) |-> !$past(severeOverCur));
  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(switchLockout) |-> $past(supplyOverThr));
  // R7
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(switchLockout) |-> $past(supplyUnderHyst));
  // R8
  ovstat_follow_chk: assert property (@(posedge clk) disable iff (rst)
    logicSupplyOk |=> (ovStatDrvLow == $past(supplyOverThr)));
  // R9
  ovstat_nologic_chk: assert property (@(posedge clk) disable iff (rst)
    !logicSupplyOk |=> (ovStatDrvLow == OVSTAT_FORCE_LOW));
endmodule

// File: rtl/outprot_supervisor.sv
module outprot_supervisor
  import outprot_pkg::*;
#(
  parameter int TICKS_PER_US     = 4,
  parameter int OC_DEGLITCH_US   = 8,
  parameter int PROTECT_US       = 4000,
  parameter int OV_FILTER_US     = 200,
  parameter bit OVSTAT_FORCE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hsOverCur,
  input  logic severeOverCur,
  input  logic supplyOverThr,
  input  logic supplyUnderHyst,
  input  logic hsSwitchOn,
  input  logic inputModeEn,
  input  logic logicSupplyOk,
  output logic ocDrvLow,
  output logic protectSlow,
  output logic switchLockout,
  output logic ovStatDrvLow
);
  localparam int OC_TICKS   = OC_DEGLITCH_US * TICKS_PER_US;
  localparam int PROT_TICKS = PROTECT_US * TICKS_PER_US;
  localparam int OV_TICKS   = OV_FILTER_US * TICKS_PER_US;

  tmrCtrl_t ctrl;
  tmrStat_t stat;

  outprot_control #(.OVSTAT_FORCE_LOW(OVSTAT_FORCE_LOW)) ctrl_i (
    .clk(clk), .rst(rst),
    .hsOverCur(hsOverCur), .severeOverCur(severeOverCur),
    .supplyOverThr(supplyOverThr), .supplyUnderHyst(supplyUnderHyst),
    .hsSwitchOn(hsSwitchOn), .inputModeEn(inputModeEn),
    .logicSupplyOk(logicSupplyOk), .stat(stat), .ctrl(ctrl),
    .ocDrvLow(ocDrvLow), .protectSlow(protectSlow),
    .switchLockout(switchLockout), .ovStatDrvLow(ovStatDrvLow));

  outprot_datapath #(
    .OC_TICKS(OC_TICKS), .PROT_TICKS(PROT_TICKS), .OV_TICKS(OV_TICKS)
  ) dp_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .stat(stat));
endmodule

// File: tb/outprot_supervisor_tb_top.sv
`timescale 1ns/1ps
module outprot_supervisor_tb_top;
  localparam int TPU   = 2;
  localparam int OC_T  = 8 * TPU;
  localparam int PR_T  = 4000 * TPU;
  localparam int OV_T  = 200 * TPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsOverCur = 0, severeOverCur = 0, supplyOverThr = 0;
  logic supplyUnderHyst = 0, hsSwitchOn = 0, inputModeEn = 0;
  logic logicSupplyOk = 1;
  logic ocDrvLow, protectSlow, switchLockout, ovStatDrvLow;
  logic oc2, pr2, lk2, ovStat2;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  outprot_supervisor #(.TICKS_PER_US(TPU), .OVSTAT_FORCE_LOW(1'b1)) dut_i (
    .clk(clk), .rst(rst), .hsOverCur(hsOverCur), .severeOverCur(severeOverCur),
    .supplyOverThr(supplyOverThr), .supplyUnderHyst(supplyUnderHyst),
    .hsSwitchOn(hsSwitchOn), .inputModeEn(inputModeEn),
    .logicSupplyOk(logicSupplyOk), .ocDrvLow(ocDrvLow),
    .protectSlow(protectSlow), .switchLockout(switchLockout),
    .ovStatDrvLow(ovStatDrvLow));

  // High-impedance variant of the status pin (R9)
  outprot_supervisor #(.TICKS_PER_US(TPU), .OVSTAT_FORCE_LOW(1'b0)) dutHiz_i (
    .clk(clk), .rst(rst), .hsOverCur(hsOverCur), .severeOverCur(severeOverCur),
    .supplyOverThr(supplyOverThr), .supplyUnderHyst(supplyUnderHyst),
    .hsSwitchOn(hsSwitchOn), .inputModeEn(inputModeEn),
    .logicSupplyOk(logicSupplyOk), .ocDrvLow(oc2),
    .protectSlow(pr2), .switchLockout(lk2), .ovStatDrvLow(ovStat2));

  task automatic chk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int ocLen = 0, ovLen = 0, protLeft = 0;
  logic eOc = 0, eProt = 0, eLock = 0, eOvs = 0, eOvs2 = 0;

  always @(posedge clk) begin
    if (rst) begin
      ocLen = 0; ovLen = 0; protLeft = 0;
      eOc = 0; eProt = 0; eLock = 0; eOvs = 0; eOvs2 = 0;
    end else begin
      if (hsOverCur && hsSwitchOn && !inputModeEn) ocLen = ocLen + 1;
      else ocLen = 0;
      eOc = (ocLen > OC_T);
      if (protLeft == 0) begin
        if (severeOverCur) protLeft = PR_T;
      end else begin
        protLeft = protLeft - 1;
        if (protLeft == 0 && severeOverCur) protLeft = PR_T;
      end
      eProt = (protLeft > 0);
      if (supplyOverThr) ovLen = ovLen + 1;
      else ovLen = 0;
      if (supplyUnderHyst) eLock = 0;
      else if (ovLen > OV_T) eLock = 1;
      eOvs  = logicSupplyOk ? supplyOverThr : 1'b1;
      eOvs2 = logicSupplyOk ? supplyOverThr : 1'b0;
    end
    #1;
    if (rst) begin
      chk(ocDrvLow, 1'b0, "R10 ocDrvLow");
      chk(protectSlow, 1'b0, "R10 protectSlow");
      chk(switchLockout, 1'b0, "R10 switchLockout");
      chk(ovStatDrvLow, 1'b0, "R10 ovStatDrvLow");
    end else begin
      chk(ocDrvLow, eOc, "R1/R2/R3 ocDrvLow");
      chk(protectSlow, eProt, "R4/R5 protectSlow");
      chk(switchLockout, eLock, "R6/R7 switchLockout");
      chk(ovStatDrvLow, eOvs, "R8/R9 ovStatDrvLow");
      chk(ovStat2, eOvs2, "R9 ovStatDrvLow hi-z variant");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R10: reset with inputs active
    supplyOverThr = 1; hsOverCur = 1; hsSwitchOn = 1; severeOverCur = 0;
    cyc(4);
    supplyOverThr = 0; hsOverCur = 0; hsSwitchOn = 0;
    rst = 0;
    cyc(3);
    // R1: run of exactly OC_T edges is too short
    hsSwitchOn = 1; hsOverCur = 1; cyc(OC_T);
    hsOverCur = 0; cyc(3);
    // R1 then R2 via current drop
    hsOverCur = 1; cyc(OC_T + 6);
    hsOverCur = 0; cyc(3);
    // R2 via switch turning off (thermal shutdown)
    hsOverCur = 1; cyc(OC_T + 6);
    hsSwitchOn = 0; cyc(3);
    hsSwitchOn = 1; cyc(OC_T + 4);
    // R3: input mode suppresses indicator
    inputModeEn = 1; cyc(OC_T * 3);
    inputModeEn = 0; cyc(OC_T + 4);
    hsOverCur = 0; cyc(2);
    // R4: short severe pulse gives one window; R5 mid-window pulse no extension
    severeOverCur = 1; cyc(2);
    severeOverCur = 0; cyc(PR_T / 2);
    severeOverCur = 1; cyc(5);
    severeOverCur = 0; cyc(PR_T);
    // R5: severe held across window ends, together with overcurrent
    severeOverCur = 1; hsOverCur = 1; cyc(2 * PR_T + 10);
    severeOverCur = 0; hsOverCur = 0; cyc(PR_T + 20);
    // R6: short excursion ignored, R8 status follows
    supplyOverThr = 1; cyc(OV_T);
    supplyOverThr = 0; cyc(5);
    // R6 lockout, R9 logic supply off during event
    supplyOverThr = 1; cyc(OV_T + 10);
    logicSupplyOk = 0; cyc(5);
    logicSupplyOk = 1; cyc(3);
    // R7: held while supply falls, cleared by hysteresis flag
    supplyOverThr = 0; cyc(20);
    logicSupplyOk = 0; cyc(4);
    logicSupplyOk = 1;
    supplyUnderHyst = 1; cyc(3);
    // R7: clear wins when over and under seen together
    supplyUnderHyst = 0; supplyOverThr = 1; cyc(OV_T + 5);
    supplyUnderHyst = 1; cyc(4);
    supplyOverThr = 0; supplyUnderHyst = 0; cyc(5);
    // R10: mid-operation reset
    hsOverCur = 1; severeOverCur = 1; cyc(OC_T + 5);
    rst = 1; cyc(3);
    rst = 0; hsOverCur = 0; severeOverCur = 0; cyc(PR_T + 5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule